// File: doc/BRIEF.md
# Rolling-Shutter Row-Group Sequencer

This block produces the digital select and clear strobes for a pixel matrix that is read out in rolling-shutter fashion. The matrix is split into row groups of four pixel rows. Each of the block's 32 channels drives one row group, so one device covers 128 physical rows. The block selects one channel at a time and steps upward from channel 0 to channel 31. Each channel's slot has a gate phase, then a clear phase applied to the same row group while it is still selected, then a one-cycle release in which only the gate stays high. The gate phase length and the clear phase length are programmable.

Devices are chained into a longer sequence by passing a token. The head device of a chain starts on an external start pulse. Every other device starts when it receives a token pulse from the device before it. When a device finishes channel 31, it sends a one-cycle token pulse and goes idle. With six devices chained, a matrix of 192 row groups is covered as one unbroken rolling frame. The head device also marks the start of each frame.

Top module: `rowgroup_sequencer`

## Requirements
- R1: Bit i of `gate_o` and bit i of `clear_o` belong to channel i. There are 32 channels by default.
- R2: At most one bit of `gate_o` is high. Channels run in ascending order from 0 to 31. Each channel's gate stays high for G+C+1 consecutive cycles, and the next channel's gate rises in the cycle right after.
- R3: A bit of `clear_o` is high only while the same bit of `gate_o` is high.
- R4: Inside a slot, the first G cycles have the gate alone. The next C cycles have gate and clear together. The final cycle has the gate alone, so clear always falls before gate.
- R5: `token_o` is high for the one cycle after channel 31's slot ends. A follower device whose `token_i` is driven from it raises `gate_o[0]` in the cycle after that.
- R6: While `token_o` is high, and from then until the next launch, all `gate_o` and `clear_o` bits are low. `token_o` never stays high for two cycles in a row.
- R7: With `first_dev`=1, the device launches on `start_i` and ignores `token_i`. With `first_dev`=0, it launches on `token_i` and ignores `start_i`. `gate_o[0]` rises in the cycle after the launch input is sampled high.
- R8: `frame_o` pulses for one cycle together with the first gate cycle of channel 0. It does so only on a device with `first_dev`=1.
- R9: G is `gate_len` and C is `clear_len`, both in clock cycles. A programmed value of 0 is treated as 1.
- R10: Both lengths are captured at launch. Changing them during a running sequence has no effect until the next launch.
- R11: Launch inputs that arrive while a sequence is running are ignored.
- R12: A synchronous reset drives every gate, clear, token and frame output low and abandons any sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| first_dev | input | 1 | 1 = head of chain (launch on start_i) |
| start_i | input | 1 | Start pulse for the head device |
| token_i | input | 1 | Token pulse from the previous device |
| gate_len | input | 8 | Gate phase length in cycles (0 acts as 1) |
| clear_len | input | 8 | Clear phase length in cycles (0 acts as 1) |
| gate_o | output | 32 | Per-channel row-group select strobes |
| clear_o | output | 32 | Per-channel clear strobes |
| token_o | output | 1 | One-cycle token pulse to the next device |
| frame_o | output | 1 | One-cycle frame start marker (head device only) |

## Verification
The assertions assume that `first_dev` is held constant while the device is out of reset. They also assume that reset is asserted before the first edge, so the registered state is defined before any property is evaluated. The bench ties `first_dev` to a constant on each of the two chained instances and asserts reset from time zero. It drives every input only at the falling edge, so the launch and length inputs are stable when they are sampled. The stimulus sends stray launch pulses during running sequences and changes the lengths mid-frame, so the ignore and capture rules are exercised against those assumptions.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

    // Phase of the sequencer within a channel slot
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_CLEAR = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/rowseq_launch_sel.sv
module rowseq_launch_sel (
    input  logic first_dev,
    input  logic start_i,
    input  logic token_i,
    output logic launch
);

    // Head of chain listens to the start pulse, followers to the token
    always_comb begin
        if (first_dev) begin
            launch = start_i;
        end else begin
            launch = token_i;
        end
    end

endmodule

// File: rtl/rowseq_phase_fsm.sv
module rowseq_phase_fsm
    import rowseq_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int PHASE_W = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               launch,
    input  logic               first_dev,
    input  logic [PHASE_W-1:0] gate_len,
    input  logic [PHASE_W-1:0] clear_len,
    output logic               active,
    output logic               clr_phase,
    output logic [CH_W-1:0]    ch,
    output logic               token_o,
    output logic               frame_o
);

    localparam logic [CH_W-1:0]    LAST_CH = CH_W'(NUM_CH - 1);
    localparam logic [PHASE_W-1:0] ONE     = PHASE_W'(1);

    typedef struct packed {
        seq_state_e         state;
        logic [CH_W-1:0]    ch;
        logic [PHASE_W-1:0] cnt;
        logic [PHASE_W-1:0] glen;
        logic [PHASE_W-1:0] clen;
        logic               token;
        logic               frame;
    } fsm_regs_t;

    fsm_regs_t r_q;
    fsm_regs_t r_d;

    // A zero length still gives a one-cycle phase
    function automatic logic [PHASE_W-1:0] clamp_len(input logic [PHASE_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    always_comb begin
        r_d       = r_q;
        r_d.token = 1'b0;
        r_d.frame = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (launch) begin
                    r_d.state = ST_GATE;
                    r_d.ch    = '0;
                    r_d.cnt   = '0;
                    r_d.glen  = clamp_len(gate_len);
                    r_d.clen  = clamp_len(clear_len);
                    r_d.frame = first_dev;
                end
            end
            ST_GATE: begin
                if (r_q.cnt == r_q.glen - ONE) begin
                    r_d.state = ST_CLEAR;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + ONE;
                end
            end
            ST_CLEAR: begin
                if (r_q.cnt == r_q.clen - ONE) begin
                    r_d.state = ST_HOLD;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + ONE;
                end
            end
            ST_HOLD: begin
                if (r_q.ch == LAST_CH) begin
                    r_d.state = ST_IDLE;
                    r_d.ch    = '0;
                    r_d.token = 1'b1;
                end else begin
                    r_d.state = ST_GATE;
                    r_d.ch    = r_q.ch + CH_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
            r_q.ch    <= '0;
            r_q.cnt   <= '0;
            r_q.glen  <= ONE;
            r_q.clen  <= ONE;
            r_q.token <= 1'b0;
            r_q.frame <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign active    = (r_q.state != ST_IDLE);
    assign clr_phase = (r_q.state == ST_CLEAR);
    assign ch        = r_q.ch;
    assign token_o   = r_q.token;
    assign frame_o   = r_q.frame;

endmodule

// File: rtl/rowseq_chan_decode.sv
module rowseq_chan_decode #(
    parameter int NUM_CH = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              active,
    input  logic              clr_phase,
    input  logic [CH_W-1:0]   ch,
    output logic [NUM_CH-1:0] gate_o,
    output logic [NUM_CH-1:0] clear_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic hit;
        assign hit        = (ch == CH_W'(i));
        assign gate_o[i]  = active & hit;
        assign clear_o[i] = clr_phase & hit;
    end

endmodule

// File: rtl/rowgroup_sequencer.sv
module rowgroup_sequencer #(
    parameter int NUM_CH  = 32,
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               first_dev,
    input  logic               start_i,
    input  logic               token_i,
    input  logic [PHASE_W-1:0] gate_len,
    input  logic [PHASE_W-1:0] clear_len,
    output logic [NUM_CH-1:0]  gate_o,
    output logic [NUM_CH-1:0]  clear_o,
    output logic               token_o,
    output logic               frame_o
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic            launch;
    logic            active;
    logic            clr_phase;
    logic [CH_W-1:0] ch;

    rowseq_launch_sel u_launch (
        .first_dev (first_dev),
        .start_i   (start_i),
        .token_i   (token_i),
        .launch    (launch)
    );

    rowseq_phase_fsm #(
        .NUM_CH  (NUM_CH),
        .PHASE_W (PHASE_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .first_dev (first_dev),
        .gate_len  (gate_len),
        .clear_len (clear_len),
        .active    (active),
        .clr_phase (clr_phase),
        .ch        (ch),
        .token_o   (token_o),
        .frame_o   (frame_o)
    );

    rowseq_chan_decode #(
        .NUM_CH (NUM_CH)
    ) u_dec (
        .active    (active),
        .clr_phase (clr_phase),
        .ch        (ch),
        .gate_o    (gate_o),
        .clear_o   (clear_o)
    );

endmodule

// File: rtl/rowseq_checker.sv
module rowseq_checker #(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              first_dev,
    input logic [NUM_CH-1:0] gate_o,
    input logic [NUM_CH-1:0] clear_o,
    input logic              token_o,
    input logic              frame_o
);

    // R2: never more than one row group selected
    a_r2_gate_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_o));

    // R3: clear only on the selected row group
    a_r3_clear_in_gate: assert property (@(posedge clk) disable iff (rst)
        (clear_o & ~gate_o) == '0);

    // R4: clear rises only after the gate was already on
    a_r4_gate_leads: assert property (@(posedge clk) disable iff (rst)
        $rose(|clear_o) |-> $past(|gate_o));

    // R4: clear falls while gate stays on
    a_r4_clear_first: assert property (@(posedge clk) disable iff (rst)
        $fell(|clear_o) |-> (|gate_o));

    // R6: token is a single-cycle pulse with outputs quiet
    a_r6_token_pulse: assert property (@(posedge clk) disable iff (rst)
        token_o |=> !token_o);
    a_r6_token_quiet: assert property (@(posedge clk) disable iff (rst)
        token_o |-> (gate_o == '0 && clear_o == '0));

    // R8: frame marker only with channel 0 on the head device
    a_r8_frame_ch0: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> (gate_o[0] && first_dev && !(|clear_o)));

    // R12: the cycle after reset everything is low
    a_r12_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gate_o == '0 && clear_o == '0 && !token_o && !frame_o));

endmodule

bind rowgroup_sequencer rowseq_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .first_dev (first_dev),
    .gate_o    (gate_o),
    .clear_o   (clear_o),
    .token_o   (token_o),
    .frame_o   (frame_o)
);

// File: tb/rowgroup_sequencer_test.sv
module rowgroup_sequencer_test;

    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic stray_tok = 1'b0;
    logic [7:0] gate_len = 8'd3;
    logic [7:0] clear_len = 8'd2;
    logic [N-1:0] gate_a, clear_a, gate_b, clear_b;
    logic tok_a, tok_b, frm_a, frm_b;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string scen = "R7";

    always #2 clk = ~clk;   // 250 MHz

    rowgroup_sequencer uut (
        .clk(clk), .rst(rst), .first_dev(1'b1), .start_i(start_i), .token_i(stray_tok),
        .gate_len(gate_len), .clear_len(clear_len),
        .gate_o(gate_a), .clear_o(clear_a), .token_o(tok_a), .frame_o(frm_a));

    rowgroup_sequencer uut_next (
        .clk(clk), .rst(rst), .first_dev(1'b0), .start_i(start_i), .token_i(tok_a),
        .gate_len(gate_len), .clear_len(clear_len),
        .gate_o(gate_b), .clear_o(clear_b), .token_o(tok_b), .frame_o(frm_b));

    // Behavioural reference: per device a cycle index since launch (-1 = idle)
    int k [2] = '{-1, -1};
    int mg [2] = '{1, 1};
    int mc [2] = '{1, 1};
    bit mtok [2] = '{0, 0};

    function automatic int clamp(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic step_dev(input int d, input bit launch_in);
        int s;
        s = mg[d] + mc[d] + 1;
        mtok[d] = 1'b0;
        if (rst) begin
            k[d] = -1;
        end else if (k[d] >= 0) begin
            k[d]++;
            if (k[d] == N * s) begin
                k[d] = -1;
                mtok[d] = 1'b1;
            end
        end else if (launch_in) begin
            k[d] = 0;
            mg[d] = clamp(int'(gate_len));
            mc[d] = clamp(int'(clear_len));
        end
    endtask

    always @(posedge clk) begin
        step_dev(1, mtok[0]);   // follower sees head's token before head updates
        step_dev(0, start_i);
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s/%s %s actual=%h expected=%h", tag, scen, what, act, exp);
        end
    endtask

    task automatic compare_dev(input int d, input logic [N-1:0] g, input logic [N-1:0] c,
                               input logic t, input logic f);
        logic [N-1:0] eg, ec;
        logic ef;
        int s, off;
        eg = '0; ec = '0; ef = 1'b0;
        s = mg[d] + mc[d] + 1;
        if (k[d] >= 0) begin
            off = k[d] % s;
            eg[k[d] / s] = 1'b1;
            if (off >= mg[d] && off < mg[d] + mc[d]) ec[k[d] / s] = 1'b1;
            ef = (d == 0) && (k[d] == 0);
        end
        check(g == eg, "R1/R2", $sformatf("dev%0d gate", d), g, eg);
        check(c == ec, "R4", $sformatf("dev%0d clear", d), c, ec);
        check((c & ~g) == '0, "R3", $sformatf("dev%0d clear outside gate", d), c & ~g, '0);
        check(t == mtok[d], "R5/R6", $sformatf("dev%0d token", d), N'(t), N'(mtok[d]));
        check(f == ef, "R8", $sformatf("dev%0d frame", d), N'(f), N'(ef));
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            compare_dev(0, gate_a, clear_a, tok_a, frm_a);
            compare_dev(1, gate_b, clear_b, tok_b, frm_b);
        end
    end

    task automatic wait_done();
        @(negedge clk);
        while (k[0] >= 0 || k[1] >= 0 || mtok[0] || mtok[1]) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs low under reset
        check(gate_a == '0 && clear_a == '0 && gate_b == '0 && clear_b == '0,
              "R12", "outputs in reset", gate_a | gate_b, '0);
        check(!tok_a && !tok_b && !frm_a && !frm_b, "R12", "token/frame in reset",
              N'({tok_a, tok_b, frm_a, frm_b}), '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R7 / R11: launch, stray token into head, stray start during the run
        scen = "R7";
        stray_tok = 1'b1; @(negedge clk); stray_tok = 1'b0;   // head must ignore
        repeat (2) @(negedge clk);
        pulse_start();
        scen = "R11";
        repeat (20) @(negedge clk);
        pulse_start();
        stray_tok = 1'b1; @(negedge clk); stray_tok = 1'b0;
        while (k[1] < 0) @(negedge clk);
        pulse_start();                                       // follower ignores start
        wait_done();

        // R9: zero lengths act as one
        scen = "R9";
        gate_len = 8'd0; clear_len = 8'd0;
        pulse_start();
        wait_done();

        // R10: lengths captured at launch
        scen = "R10";
        gate_len = 8'd2; clear_len = 8'd4;
        pulse_start();
        repeat (10) @(negedge clk);
        gate_len = 8'd7; clear_len = 8'd1;
        wait_done();

        // R12: reset abandons a running frame
        scen = "R12";
        gate_len = 8'd1; clear_len = 8'd1;
        pulse_start();
        repeat (50) @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(gate_a == '0 && clear_a == '0, "R12", "head after mid-run reset", gate_a, '0);
        repeat (5) @(negedge clk);
        pulse_start();
        wait_done();

        finish_run();
    end

endmodule